// File: doc/BRIEF.md
# Load/Store Address Buffer

This block holds memory operations between instruction issue and a single memory port in an out-of-order floating-point datapath. Each accepted operation brings a base operand, either as a value or as the tag of the producer that will deliver it, and a sign-extended offset. The entry's address field starts out holding the offset. Once the base value is present, the field is overwritten with the effective address. Address generation runs strictly in program order, one entry per cycle.

Loads with a known address go to memory as soon as the port is free. A load may overtake older stores only when every one of them already has a known address and none of those addresses matches. The read data goes out on the result bus one cycle later, tagged with the load's own tag. A store waits until both its address and its data are present, and it writes memory only as the oldest entry. Pending base and store-data operands are taken from the common result bus by tag match, including in the cycle of issue. Full flags per operation type stall issue.

Top module: `lsq_addr_buf`

## Requirements
- R1: After reset, `ld_full`, `st_full`, `mem_req` and `res_valid` are all 0 and the buffer is empty.
- R2: `ld_full` is 1 exactly when N_LD loads are held, and `st_full` is 1 exactly when N_ST stores are held. While the flag for a type is 1, an issue of that type (`iss_store` 0 = load, 1 = store) is ignored and never produces a memory access or a result.
- R3: The effective address is base + offset modulo 2^AW. A pending base is taken from `cdb_data[AW-1:0]` when `cdb_valid` is 1 and `cdb_tag` equals the waiting tag. This includes a broadcast in the same cycle as the issue.
- R4: Effective addresses are formed in program order. No operation touches memory while an older entry's address is still unknown.
- R5: `mem_req` is 1 only in a cycle where `mem_ready` is 1, and at most one access is made per cycle.
- R6: In the cycle after a load's read (`mem_req`=1, `mem_we`=0), `res_valid` is 1. At that point `res_tag` is the load's tag and `res_data` is the `mem_rdata` of the read cycle.
- R7: A store does not write until its data is present. Pending data is captured from the result bus by tag, including in the issue cycle. The write drives `mem_we`=1, `mem_addr` and `mem_wdata`, and stores write in program order.
- R8: A load passes an older store only if that store's address is known and differs from the load's. Otherwise the load waits, and after the store it returns the stored data.
- R9: A store writes only while it is the oldest held entry. When it is ready, it takes the port ahead of any load.
- R10: Every accepted operation completes once its operands have arrived and the port is free, and it releases its entry, which clears the matching full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_rtag | input | TW | Tag a load broadcasts its result with |
| iss_base_rdy | input | 1 | Base value present at issue |
| iss_base_val | input | AW | Base value |
| iss_base_tag | input | TW | Producer tag of a pending base |
| iss_off | input | AW | Sign-extended offset |
| iss_data_rdy | input | 1 | Store data present at issue |
| iss_data_val | input | DW | Store data value |
| iss_data_tag | input | TW | Producer tag of pending store data |
| ld_full | output | 1 | No free load entry |
| st_full | output | 1 | No free store entry |
| cdb_valid | input | 1 | Result bus broadcast valid |
| cdb_tag | input | TW | Result bus producer tag |
| cdb_data | input | DW | Result bus value |
| mem_ready | input | 1 | Memory port can take an access |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the request cycle |
| res_valid | output | 1 | Load result valid |
| res_tag | output | TW | Load result tag |
| res_data | output | DW | Load result data |

## Verification
The assertions assume that `mem_rdata` is combinationally valid in the read cycle. They also assume that each producer tag is broadcast once, with a single value, while operations wait on it. The bench keeps its memory model asynchronous-read. It gives every pending operand in a batch its own producer tag and lets each batch drain before the next batch reuses tags. Random offsets are chosen so that every address stays inside the bench's small memory model.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;
    typedef enum logic {
        KIND_LD = 1'b0,
        KIND_ST = 1'b1
    } lsq_kind_e;
endpackage

// File: rtl/lsq_ea_sel.sv
`timescale 1ns/1ps
// Finds the oldest held entry whose effective address is still unknown.
module lsq_ea_sel #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]    cnt,
    input  logic [DEPTH-1:0] ea_ok,
    output logic             found,
    output logic [IDXW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if ((CW'(i) < cnt) && !ea_ok[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/lsq_ld_sel.sv
`timescale 1ns/1ps
// Picks the oldest load that may read memory without overtaking a
// conflicting or unresolved older store.
module lsq_ld_sel #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]            cnt,
    input  logic [DEPTH-1:0]         is_st,
    input  logic [DEPTH-1:0]         ea_ok,
    input  logic [DEPTH-1:0][AW-1:0] addr,
    output logic                     found,
    output logic [IDXW-1:0]          idx
);
    logic [DEPTH-1:0] blk;
    logic [DEPTH-1:0] cand;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blk[i] = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (is_st[j] && (!ea_ok[j] || (addr[j] == addr[i]))) begin
                    blk[i] = 1'b1;
                end
            end
            cand[i] = (CW'(i) < cnt) && !is_st[i] && ea_ok[i] && !blk[i];
        end
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/lsq_addr_buf.sv
`timescale 1ns/1ps
module lsq_addr_buf
    import lsq_pkg::*;
#(
    parameter int N_LD = 4,
    parameter int N_ST = 4,
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int TW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic          iss_store,
    input  logic [TW-1:0] iss_rtag,
    input  logic          iss_base_rdy,
    input  logic [AW-1:0] iss_base_val,
    input  logic [TW-1:0] iss_base_tag,
    input  logic [AW-1:0] iss_off,
    input  logic          iss_data_rdy,
    input  logic [DW-1:0] iss_data_val,
    input  logic [TW-1:0] iss_data_tag,
    output logic          ld_full,
    output logic          st_full,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic [DW-1:0] cdb_data,
    input  logic          mem_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          res_valid,
    output logic [TW-1:0] res_tag,
    output logic [DW-1:0] res_data
);
    localparam int DEPTH = N_LD + N_ST;
    localparam int IDXW  = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        lsq_kind_e     kind;
        logic [TW-1:0] rtag;
        logic          base_ok;
        logic [TW-1:0] base_tag;
        logic [AW-1:0] base;
        logic          ea_ok;
        logic [AW-1:0] a;        // offset until resolved, then effective address
        logic          data_ok;
        logic [TW-1:0] data_tag;
        logic [DW-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;   // index 0 is the oldest
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    nld;
        logic [CW-1:0]    nst;
        logic             rv;
        logic [TW-1:0]    rtag;
        logic [DW-1:0]    rdata;
    } state_t;

    state_t s_q, s_d;
    ent_t [DEPTH-1:0] upd;
    ent_t nw;

    logic [DEPTH-1:0]         v_ea, v_st;
    logic [DEPTH-1:0][AW-1:0] v_a;
    logic                     ea_found, ld_found;
    logic [IDXW-1:0]          ea_idx, ld_idx;
    logic                     head_st, acc, rem;
    logic [IDXW-1:0]          rem_idx;
    logic [CW-1:0]            cnt_m;
    logic                     req_c, we_c;
    logic [AW-1:0]            addr_c;
    logic [DW-1:0]            wdata_c;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            v_ea[i] = s_q.ent[i].ea_ok;
            v_st[i] = (s_q.ent[i].kind == KIND_ST);
            v_a[i]  = s_q.ent[i].a;
        end
    end

    lsq_ea_sel #(.DEPTH(DEPTH)) u_ea_sel (
        .cnt   (s_q.cnt),
        .ea_ok (v_ea),
        .found (ea_found),
        .idx   (ea_idx)
    );

    lsq_ld_sel #(.DEPTH(DEPTH), .AW(AW)) u_ld_sel (
        .cnt   (s_q.cnt),
        .is_st (v_st),
        .ea_ok (v_ea),
        .addr  (v_a),
        .found (ld_found),
        .idx   (ld_idx)
    );

    assign ld_full = (s_q.nld == CW'(N_LD));
    assign st_full = (s_q.nst == CW'(N_ST));

    always_comb begin
        // operand snoop on the result bus
        upd = s_q.ent;
        for (int i = 0; i < DEPTH; i++) begin
            if (cdb_valid && !upd[i].base_ok && (upd[i].base_tag == cdb_tag)) begin
                upd[i].base_ok = 1'b1;
                upd[i].base    = cdb_data[AW-1:0];
            end
            if (cdb_valid && (upd[i].kind == KIND_ST) && !upd[i].data_ok &&
                (upd[i].data_tag == cdb_tag)) begin
                upd[i].data_ok = 1'b1;
                upd[i].data    = cdb_data;
            end
        end
        // in-order address generation, one entry per cycle
        if (ea_found && s_q.ent[ea_idx].base_ok) begin
            upd[ea_idx].a     = s_q.ent[ea_idx].base + s_q.ent[ea_idx].a;
            upd[ea_idx].ea_ok = 1'b1;
        end

        // memory port: a ready head store first, otherwise the oldest safe load
        s_d     = s_q;
        s_d.rv  = 1'b0;
        req_c   = 1'b0;
        we_c    = 1'b0;
        addr_c  = '0;
        wdata_c = '0;
        rem     = 1'b0;
        rem_idx = '0;
        head_st = (s_q.cnt != '0) && (s_q.ent[0].kind == KIND_ST) &&
                  s_q.ent[0].ea_ok && s_q.ent[0].data_ok;
        if (mem_ready) begin
            if (head_st) begin
                req_c   = 1'b1;
                we_c    = 1'b1;
                addr_c  = s_q.ent[0].a;
                wdata_c = s_q.ent[0].data;
                rem     = 1'b1;
                s_d.nst = s_q.nst - CW'(1);
            end else if (ld_found) begin
                req_c     = 1'b1;
                addr_c    = s_q.ent[ld_idx].a;
                rem       = 1'b1;
                rem_idx   = ld_idx;
                s_d.nld   = s_q.nld - CW'(1);
                s_d.rv    = 1'b1;
                s_d.rtag  = s_q.ent[ld_idx].rtag;
                s_d.rdata = mem_rdata;
            end
        end

        // collapse the released slot
        cnt_m = s_q.cnt - CW'(rem);
        for (int i = 0; i < DEPTH - 1; i++) begin
            s_d.ent[i] = (rem && (IDXW'(i) >= rem_idx)) ? upd[i + 1] : upd[i];
        end
        s_d.ent[DEPTH-1] = upd[DEPTH-1];

        // append the newly issued operation
        acc         = iss_valid && (iss_store ? !st_full : !ld_full);
        nw          = '0;
        nw.kind     = iss_store ? KIND_ST : KIND_LD;
        nw.rtag     = iss_rtag;
        nw.base_tag = iss_base_tag;
        nw.base_ok  = iss_base_rdy || (cdb_valid && (cdb_tag == iss_base_tag));
        nw.base     = iss_base_rdy ? iss_base_val : cdb_data[AW-1:0];
        nw.a        = iss_off;
        nw.data_tag = iss_data_tag;
        nw.data_ok  = iss_data_rdy || (cdb_valid && (cdb_tag == iss_data_tag));
        nw.data     = iss_data_rdy ? iss_data_val : cdb_data;
        if (acc) begin
            s_d.ent[cnt_m[IDXW-1:0]] = nw;
            if (iss_store) s_d.nst = s_d.nst + CW'(1);
            else           s_d.nld = s_d.nld + CW'(1);
        end
        s_d.cnt = cnt_m + CW'(acc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_req   = req_c;
    assign mem_we    = we_c;
    assign mem_addr  = addr_c;
    assign mem_wdata = wdata_c;
    assign res_valid = s_q.rv;
    assign res_tag   = s_q.rtag;
    assign res_data  = s_q.rdata;

    p_req_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_ready);

    p_res_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> res_valid);

    p_res_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(mem_req && !mem_we));

    p_ldfull_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_full && !(mem_req && !mem_we)) |=> ld_full);

    p_st_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !st_full);

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_order
            p_ea_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ((CW'(g) < s_q.cnt) && s_q.ent[g].ea_ok) |-> s_q.ent[g-1].ea_ok);
        end
    endgenerate
endmodule

// File: tb/tb_lsq_addr_buf.sv
`timescale 1ns/1ps
module tb_lsq_addr_buf;
    localparam int AW = 16, DW = 32, TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          iss_valid = 0, iss_store = 0, iss_base_rdy = 0, iss_data_rdy = 0;
    logic [TW-1:0] iss_rtag = '0, iss_base_tag = '0, iss_data_tag = '0;
    logic [AW-1:0] iss_base_val = '0, iss_off = '0;
    logic [DW-1:0] iss_data_val = '0;
    logic          ld_full, st_full;
    logic          cdb_valid = 0;
    logic [TW-1:0] cdb_tag = '0;
    logic [DW-1:0] cdb_data = '0;
    logic          mem_ready = 0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          res_valid;
    logic [TW-1:0] res_tag;
    logic [DW-1:0] res_data;

    lsq_addr_buf dut (.*);

    logic [DW-1:0] mem [64];
    logic [DW-1:0] shadow [64];
    assign mem_rdata = mem[mem_addr[5:0]];

    int checks = 0, errors = 0, cyc = 0;
    logic [DW-1:0] exp_val [16];
    bit            exp_pend [16];
    logic [DW-1:0] prod_val [16];
    logic [AW-1:0] sq_a [1024];
    logic [DW-1:0] sq_d [1024];
    int sq_h = 0, sq_t = 0, ld_out = 0;
    int res_cnt = 0, req_cnt = 0, stw_cnt = 0;
    bit rnd_ready = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic monitor();
        if (!rst_n) return;
        if (res_valid) begin
            res_cnt++;
            if (!exp_pend[res_tag]) chk(0, "R6", "result with unexpected tag (R2 ignored issue?)", 64'(res_tag), 64'hff);
            else begin
                chk(res_data == exp_val[res_tag], "R3 R8", "load data", 64'(res_data), 64'(exp_val[res_tag]));
                exp_pend[res_tag] = 0;
                ld_out--;
            end
        end
        if (mem_req) begin
            req_cnt++;
            if (!mem_ready) chk(0, "R5", "request without port ready", 64'(mem_req), 64'(0));
        end
        if (mem_req && mem_we) begin
            stw_cnt++;
            if (sq_h == sq_t) chk(0, "R9", "unexpected store write", 64'(mem_addr), 64'(0));
            else begin
                chk(mem_addr == sq_a[sq_h], "R7", "store address", 64'(mem_addr), 64'(sq_a[sq_h]));
                chk(mem_wdata == sq_d[sq_h], "R7", "store data", 64'(mem_wdata), 64'(sq_d[sq_h]));
                sq_h++;
            end
            mem[mem_addr[5:0]] = mem_wdata;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic tick();
        @(negedge clk);
        monitor();
        @(posedge clk);
        #1;
        cyc++;
        if (cyc > 150000) begin
            chk(0, "R10", "watchdog expired", 64'(cyc), 64'(0));
            summary();
        end
        if (rnd_ready) mem_ready = ($urandom % 4) != 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic issue_op(bit st, logic [TW-1:0] rtag, logic [AW-1:0] base, int off,
                            bit bp, logic [TW-1:0] btag, logic [DW-1:0] data,
                            bit dp, logic [TW-1:0] dtag);
        logic [AW-1:0] ea;
        bit taken;
        ea = base + AW'(off);
        iss_valid = 1; iss_store = st; iss_rtag = rtag;
        iss_base_rdy = !bp; iss_base_val = bp ? '0 : base; iss_base_tag = btag;
        iss_off = AW'(off);
        iss_data_rdy = !dp; iss_data_val = dp ? '0 : data; iss_data_tag = dtag;
        taken = st ? !st_full : !ld_full;
        if (taken) begin
            if (bp) prod_val[btag] = DW'(base);
            if (st) begin
                if (dp) prod_val[dtag] = data;
                shadow[ea[5:0]] = data;
                sq_a[sq_t] = ea; sq_d[sq_t] = data; sq_t++;
            end else begin
                exp_val[rtag] = shadow[ea[5:0]];
                exp_pend[rtag] = 1;
                ld_out++;
            end
        end
        tick();
        iss_valid = 0;
    endtask

    task automatic bcast(logic [TW-1:0] tag);
        cdb_valid = 1; cdb_tag = tag; cdb_data = prod_val[tag];
        tick();
        cdb_valid = 0;
    endtask

    task automatic drain(string req);
        int n = 0;
        while ((ld_out > 0 || sq_h != sq_t) && n < 400) begin tick(); n++; end
        tick(); tick();
        chk(ld_out == 0 && sq_h == sq_t, req, "all operations completed", 64'(ld_out), 64'(0));
    endtask

    initial begin
        int r0, q0, w0;
        int order [16];
        void'($urandom(32'd6461));
        for (int i = 0; i < 64; i++) begin
            mem[i] = 32'hA000_0000 | DW'(i);
            shadow[i] = mem[i];
        end
        for (int i = 0; i < 16; i++) begin exp_pend[i] = 0; prod_val[i] = '0; exp_val[i] = '0; end
        ticks(3);
        rst_n = 1;
        #1;
        chk(!ld_full && !st_full, "R1", "full flags after reset", 64'({ld_full, st_full}), 64'(0));
        chk(!mem_req && !res_valid, "R1", "idle outputs after reset", 64'({mem_req, res_valid}), 64'(0));

        // R2 / R5: fill the loads with the port stalled
        mem_ready = 0;
        for (int i = 0; i < 4; i++) issue_op(0, TW'(i), 16'd8, i * 4, 0, '0, '0, 0, '0);
        chk(ld_full == 1, "R2", "ld_full with four loads", 64'(ld_full), 64'(1));
        chk(st_full == 0, "R2", "st_full with no stores", 64'(st_full), 64'(0));
        issue_op(0, 4'd9, 16'd30, 0, 0, '0, '0, 0, '0);
        q0 = req_cnt;
        ticks(5);
        chk(req_cnt == q0, "R5", "no access while port busy", 64'(req_cnt - q0), 64'(0));
        mem_ready = 1;
        drain("R10");
        chk(ld_full == 0, "R10", "ld_full released", 64'(ld_full), 64'(0));

        // R2 / R7: stores held for data
        for (int i = 0; i < 4; i++)
            issue_op(1, '0, 16'd40, i, 0, '0, 32'h5100_0000 | DW'(i), 1, TW'(i));
        chk(st_full == 1, "R2", "st_full with four stores", 64'(st_full), 64'(1));
        w0 = stw_cnt;
        ticks(5);
        chk(stw_cnt == w0, "R7", "no write before data", 64'(stw_cnt - w0), 64'(0));
        for (int i = 3; i >= 0; i--) bcast(TW'(i));
        drain("R7");
        chk(st_full == 0, "R10", "st_full released", 64'(st_full), 64'(0));

        // R4: younger ready load stays behind an older unresolved address
        issue_op(0, 4'd0, 16'd12, 2, 1, 4'd5, '0, 0, '0);
        issue_op(0, 4'd1, 16'd20, -3, 0, '0, '0, 0, '0);
        q0 = req_cnt;
        ticks(6);
        chk(req_cnt == q0, "R4", "no access before older address", 64'(req_cnt - q0), 64'(0));
        bcast(4'd5);
        drain("R4");

        // R8: pass on differing address, wait on matching one
        issue_op(1, '0, 16'd20, 0, 0, '0, 32'hCAFE_0001, 1, 4'd2);
        issue_op(0, 4'd0, 16'd30, 0, 0, '0, '0, 0, '0);
        r0 = res_cnt;
        ticks(6);
        chk(res_cnt == r0 + 1, "R8", "load passes store to other address", 64'(res_cnt - r0), 64'(1));
        issue_op(0, 4'd1, 16'd16, 4, 0, '0, '0, 0, '0);
        r0 = res_cnt;
        ticks(6);
        chk(res_cnt == r0, "R8", "load held behind matching store", 64'(res_cnt - r0), 64'(0));
        bcast(4'd2);
        drain("R8");

        // R9: ready store behind an unresolved older load
        issue_op(0, 4'd0, 16'd10, 0, 1, 4'd7, '0, 0, '0);
        issue_op(1, '0, 16'd12, 0, 0, '0, 32'hBEEF_0009, 0, '0);
        w0 = stw_cnt;
        ticks(6);
        chk(stw_cnt == w0, "R9", "store waits to be oldest", 64'(stw_cnt - w0), 64'(0));
        bcast(4'd7);
        drain("R9");

        // R3 / R7: operands delivered in the issue cycle
        cdb_valid = 1; cdb_tag = 4'd4; cdb_data = 32'd25;
        issue_op(0, 4'd2, 16'd25, 3, 1, 4'd4, '0, 0, '0);
        cdb_valid = 1; cdb_tag = 4'd6; cdb_data = 32'h7777_1234;
        issue_op(1, '0, 16'd40, 0, 0, '0, 32'h7777_1234, 1, 4'd6);
        cdb_valid = 0;
        issue_op(0, 4'd3, 16'd36, 4, 0, '0, '0, 0, '0);
        drain("R3");

        // random batches
        rnd_ready = 1;
        for (int b = 0; b < 80; b++) begin
            int nl, ns, p, li;
            nl = int'($urandom % 5); ns = int'($urandom % 5);
            if (nl + ns == 0) nl = 1;
            p = 0; li = 0;
            while (nl + ns > 0) begin
                bit st, bp, dp;
                logic [AW-1:0] base;
                int off;
                logic [TW-1:0] bt, dt;
                st = (ns > 0) && ((nl == 0) || ($urandom % 2 == 1));
                base = AW'(8 + int'($urandom % 32));
                off = int'($urandom % 24) - 8;
                bp = ($urandom % 2) == 1;
                dp = st && (($urandom % 2) == 1);
                bt = TW'(p); if (bp) p++;
                dt = TW'(p); if (dp) p++;
                issue_op(st, TW'(li + 4 * (b % 4)), base, off, bp, bt, $urandom, dp, dt);
                if (st) ns--; else begin nl--; li++; end
                if ($urandom % 3 == 0) tick();
            end
            for (int i = 0; i < p; i++) order[i] = i;
            for (int i = 0; i < p; i++) begin
                int j, t;
                j = int'($urandom % 32'(p));
                t = order[i]; order[i] = order[j]; order[j] = t;
            end
            for (int i = 0; i < p; i++) begin
                bcast(TW'(order[i]));
                ticks(int'($urandom % 3));
            end
            drain("R10");
        end
        rnd_ready = 0;
        mem_ready = 1;
        for (int i = 0; i < 64; i++)
            if (mem[i] != shadow[i]) chk(0, "R7", "final memory word", 64'(mem[i]), 64'(shadow[i]));
        chk(1, "R7", "final memory compared", 64'(0), 64'(0));
        summary();
    end
endmodule